// File: doc/BRIEF.md
# Shadow-Copy Store/Recall Transfer Engine

The block holds a small working memory that the host reads and writes through a plain synchronous port, next to a shadow array of the same size that stands in for nonvolatile storage and is kept in ordinary registers. A store request copies the whole working memory into the shadow array, one word per clock. A recall request first wipes the working memory one word per clock and then reloads it, word by word, from the shadow array. Each transfer runs as a fixed-length loop over all addresses.

While either transfer runs, the engine raises `busy` and locks the host out. Reads return zero and writes are dropped. A supply-low flag stops host writes and refuses new store requests, so a failing supply cannot commit a half-written image. Recall stays available under that flag. Requests that arrive while a transfer is running are discarded rather than queued.

The host port carries no data stream that can be stalled. Every access completes in a fixed cycle, and the lockout discards accesses instead of holding them back. For that reason it is a plain enable/write-enable port rather than valid/ready.

Top module: `shadow_xfer_engine`

## Requirements
- R1: After reset `busy` is 0, `mem_rdata` is 0 and every working word reads 0. The shadow word at index i holds (i*PRE_MUL + PRE_ADD) mod 2^DATA_W, which is (29i+7) mod 256 with the default parameters.
- R2: A read (`mem_en`=1, `mem_we`=0) issued while `busy` is 0 returns the addressed word on `mem_rdata` one clock later. In any cycle that does not carry a read, `mem_rdata` is 0 one clock later.
- R3: A write (`mem_en`=1, `mem_we`=1) issued while `busy` is 0 and `supply_low` is 0 replaces the addressed working word.
- R4: A write issued while `supply_low` is 1 leaves the working memory unchanged.
- R5: A store request seen while `busy` is 0 and `supply_low` is 0 raises `busy` on the next clock and keeps it high for exactly 2^ADDR_W cycles. Afterwards the shadow array equals the working memory as it stood when the request was taken, and the working memory is unchanged.
- R6: A store request seen while `supply_low` is 1 is ignored. `busy` stays 0 and the shadow array keeps its contents.
- R7: A recall request seen while `busy` is 0 keeps `busy` high for exactly 2*2^ADDR_W cycles. That time is a clearing phase over every word followed by a loading phase over every word. Afterwards each working word equals the matching shadow word.
- R8: Recall does not change the shadow array. It is accepted whatever the value of `supply_low`, and repeated recalls give identical working contents.
- R9: While `busy` is 1, reads return 0 and writes are discarded.
- R10: Store or recall requests that arrive while `busy` is 1 are dropped and do not extend the running transfer.
- R11: If store and recall are requested in the same idle cycle, only the store is carried out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | input | 1 | Host access enable |
| mem_we | input | 1 | Host access is a write when 1, a read when 0 |
| mem_addr | input | ADDR_W | Host word address |
| mem_wdata | input | DATA_W | Host write data |
| mem_rdata | output | DATA_W | Registered read data, zero when no valid read was issued |
| supply_low | input | 1 | Low-supply flag: blocks host writes and store starts |
| store_req | input | 1 | Request to copy working memory into the shadow array |
| recall_req | input | 1 | Request to clear and reload working memory from the shadow array |
| busy | output | 1 | High for the whole duration of a store or recall |

## Verification
Every cycle, the checker confirms that reads return zero during a lockout and when no read is issued, that a refused store leaves `busy` low, that an accepted store raises `busy`, that each busy period lasts exactly one or two passes over the array depending on which request was taken, and that the clearing phase always hands over to the loading phase. Data contents can only be shown by the bench's scenarios. These are: the shadow image a store leaves behind, the recalled working contents, writes dropped under low supply or lockout, the contents after repeated recalls, and which request wins when both arrive together. The bench observes all of them by sweeping reads over every address and comparing against values it computes itself.

// File: rtl/shx_pkg.sv
package shx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_STORE = 2'd1,
    PH_CLEAR = 2'd2,
    PH_LOAD  = 2'd3
  } shx_phase_e;

  // Power-up image of the shadow array, one value per word index.
  function automatic int unsigned shadow_init(int unsigned idx, int unsigned mul, int unsigned add);
    return idx * mul + add;
  endfunction

endpackage

// File: rtl/shx_seq.sv
module shx_seq
  import shx_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_req,
  input  logic              recall_req,
  input  logic              supply_low,
  output shx_phase_e        phase_q,
  output logic [ADDR_W-1:0] idx_q,
  output logic              busy
);

  shx_phase_e        phase_d;
  logic [ADDR_W-1:0] idx_d;
  logic              at_last;

  assign at_last = (idx_q == {ADDR_W{1'b1}});
  assign busy    = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q + 1'b1;
    case (phase_q)
      PH_IDLE: begin
        idx_d = '0;
        // store outranks recall when both arrive together
        if (store_req && !supply_low) begin
          phase_d = PH_STORE;
        end else if (recall_req) begin
          phase_d = PH_CLEAR;
        end
      end
      PH_STORE: if (at_last) phase_d = PH_IDLE;
      PH_CLEAR: if (at_last) phase_d = PH_LOAD;
      PH_LOAD:  if (at_last) phase_d = PH_IDLE;
      default: begin
        phase_d = PH_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/shx_work_array.sv
module shx_work_array
  import shx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shx_phase_e        phase,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] load_data,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] xfer_rdata,
  output logic [DATA_W-1:0] host_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] words;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;
    logic              hit_xfer;

    assign hit_xfer = (idx == ADDR_W'(g));

    always_comb begin
      word_d = word_q;
      if (phase == PH_CLEAR && hit_xfer) begin
        word_d = '0;
      end else if (phase == PH_LOAD && hit_xfer) begin
        word_d = load_data;
      end else if (host_wr && host_addr == ADDR_W'(g)) begin
        word_d = host_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign words[g] = word_q;
  end

  assign xfer_rdata = words[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= words[host_addr];
    else              host_rdata <= '0;
  end

endmodule

// File: rtl/shx_shadow_array.sv
module shx_shadow_array
  import shx_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int PRE_MUL = 29,
  parameter int PRE_ADD = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [DATA_W-1:0] INIT =
      DATA_W'(shadow_init(g, PRE_MUL, PRE_ADD));
    logic [DATA_W-1:0] cell_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cell_q <= INIT;
      else if (wr_en && idx == ADDR_W'(g))  cell_q <= wdata;
    end

    assign cells[g] = cell_q;
  end

  assign rdata = cells[idx];

endmodule

// File: rtl/shadow_xfer_engine.sv
module shadow_xfer_engine
  import shx_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int PRE_MUL = 29,
  parameter int PRE_ADD = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_en,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  input  logic              supply_low,
  input  logic              store_req,
  input  logic              recall_req,
  output logic              busy
);

  shx_phase_e        phase_q;
  logic [ADDR_W-1:0] idx_q;
  logic [DATA_W-1:0] work_xfer;
  logic [DATA_W-1:0] shadow_xfer;
  logic              host_wr;
  logic              host_rd;

  assign host_wr = mem_en &  mem_we & ~busy & ~supply_low;
  assign host_rd = mem_en & ~mem_we & ~busy;

  shx_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_req  (store_req),
    .recall_req (recall_req),
    .supply_low (supply_low),
    .phase_q    (phase_q),
    .idx_q      (idx_q),
    .busy       (busy)
  );

  shx_work_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_work (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase_q),
    .idx        (idx_q),
    .load_data  (shadow_xfer),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (mem_addr),
    .host_wdata (mem_wdata),
    .xfer_rdata (work_xfer),
    .host_rdata (mem_rdata)
  );

  shx_shadow_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PRE_MUL(PRE_MUL),
    .PRE_ADD(PRE_ADD)
  ) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (phase_q == PH_STORE),
    .idx   (idx_q),
    .wdata (work_xfer),
    .rdata (shadow_xfer)
  );

endmodule

// File: rtl/shx_checker.sv
module shx_checker
  import shx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              supply_low,
  input logic              store_req,
  input logic              recall_req,
  input logic              busy,
  input shx_phase_e        phase
);

  int unsigned run_len_q;
  int unsigned want_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len_q  <= 0;
      want_len_q <= 0;
    end else begin
      run_len_q <= busy ? run_len_q + 1 : 0;
      if (!busy && store_req && !supply_low) want_len_q <= DEPTH;
      else if (!busy && recall_req)          want_len_q <= 2 * DEPTH;
    end
  end

  AST_LOCKOUT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_en && !mem_we |=> mem_rdata == '0); // R9

  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_en && !mem_we) |=> mem_rdata == '0); // R2

  AST_LOW_SUPPLY_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && store_req && supply_low && !recall_req |=> !busy); // R6

  AST_STORE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && store_req && !supply_low |=> busy && phase == PH_STORE); // R11

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(busy) |-> run_len_q == want_len_q); // R10

  AST_CLEAR_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phase) == PH_CLEAR && phase != PH_CLEAR |-> phase == PH_LOAD); // R7

endmodule

bind shadow_xfer_engine shx_checker #(.DEPTH(1 << ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_rdata  (mem_rdata),
  .supply_low (supply_low),
  .store_req  (store_req),
  .recall_req (recall_req),
  .busy       (busy),
  .phase      (phase_q)
);

// File: tb/tb_shadow_xfer_engine.sv
`timescale 1ns/1ps
module tb_shadow_xfer_engine;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mem_en = 1'b0;
  logic              mem_we = 1'b0;
  logic [ADDR_W-1:0] mem_addr = '0;
  logic [DATA_W-1:0] mem_wdata = '0;
  logic [DATA_W-1:0] mem_rdata;
  logic              supply_low = 1'b0;
  logic              store_req = 1'b0;
  logic              recall_req = 1'b0;
  logic              busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int m_work [DEPTH];
  int m_shadow [DEPTH];

  always #4 clk = ~clk;

  shadow_xfer_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .supply_low(supply_low), .store_req(store_req), .recall_req(recall_req),
    .busy(busy)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    mem_en = 1; mem_we = 1; mem_addr = ADDR_W'(a); mem_wdata = DATA_W'(d);
    @(negedge clk);
    mem_en = 0; mem_we = 0;
  endtask

  task automatic rd_check(int a, int exp, string req);
    mem_en = 1; mem_we = 0; mem_addr = ADDR_W'(a);
    @(negedge clk);
    mem_en = 0;
    check(req, int'(mem_rdata), exp);
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < DEPTH; a++) rd_check(a, m_work[a], req);
  endtask

  task automatic start_req(bit s, bit r);
    store_req = s; recall_req = r;
    @(negedge clk);
    store_req = 0; recall_req = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    for (int i = 0; i < DEPTH; i++) begin
      m_work[i]   = 0;
      m_shadow[i] = (i * 29 + 7) % 256;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 rdata after reset", int'(mem_rdata), 0);
    sweep("R1 working zero");

    // recall of the power-up shadow image
    start_req(0, 1);
    measure(n);
    check("R7 recall length", n, 2 * DEPTH);
    for (int i = 0; i < DEPTH; i++) m_work[i] = m_shadow[i];
    sweep("R7 recalled preload (R1 shadow)");

    // host writes
    for (int a = 0; a < DEPTH; a++) begin
      m_work[a] = (a * 13 + 1) % 256;
      wr(a, m_work[a]);
    end
    check("R2 rdata zero after write", int'(mem_rdata), 0);
    sweep("R3 write readback");

    // low supply blocks writes and store
    supply_low = 1;
    for (int a = 0; a < DEPTH; a++) wr(a, (a * 7 + 200) % 256);
    sweep("R4 writes blocked");
    start_req(1, 0);
    check("R6 store refused busy", int'(busy), 0);
    supply_low = 0;
    start_req(0, 1);
    measure(n);
    for (int i = 0; i < DEPTH; i++) m_work[i] = m_shadow[i];
    sweep("R6 shadow kept after refused store");

    // store with lockout probes
    for (int a = 0; a < DEPTH; a++) begin
      m_work[a] = (a * 13 + 1) % 256;
      wr(a, m_work[a]);
    end
    start_req(1, 0);
    check("R5 busy after store", int'(busy), 1);
    mem_en = 1; mem_we = 0; mem_addr = 3;
    @(negedge clk);
    mem_en = 0;
    check("R9 read zero while busy", int'(mem_rdata), 0);
    mem_en = 1; mem_we = 1; mem_addr = 3; mem_wdata = 8'hAA;
    @(negedge clk);
    mem_en = 0; mem_we = 0;
    store_req = 1;
    @(negedge clk);
    store_req = 0;
    measure(n);
    check("R5 R10 store length", 3 + n, DEPTH);
    for (int i = 0; i < DEPTH; i++) m_shadow[i] = m_work[i];
    rd_check(3, m_work[3], "R9 write discarded");
    sweep("R5 working unchanged by store");

    // overwrite, then recall twice
    for (int a = 0; a < DEPTH; a++) wr(a, (a * 5 + 77) % 256);
    start_req(0, 1);
    measure(n);
    check("R7 recall length 2", n, 2 * DEPTH);
    sweep("R7 recalled stored image");
    supply_low = 1;
    start_req(0, 1);
    measure(n);
    check("R8 recall under low supply", n, 2 * DEPTH);
    sweep("R8 repeat recall same");
    supply_low = 0;

    // simultaneous requests: store wins
    for (int a = 0; a < DEPTH; a++) begin
      m_work[a] = 255 - a * 3;
      wr(a, m_work[a]);
    end
    start_req(1, 1);
    measure(n);
    check("R11 store chosen length", n, DEPTH);
    sweep("R11 working intact");
    for (int a = 0; a < DEPTH; a++) wr(a, 0);
    start_req(0, 1);
    measure(n);
    sweep("R11 shadow holds stored image");

    finish_run();
  end

endmodule